// File: doc/BRIEF.md
# Snooping MOSI Line Coherence Controller

This block runs the coherence protocol for one line of a private cache that sits on a broadcast snooping system. It takes processor loads, instruction fetches, stores and evictions, with an optional prefetch hint on each. It also observes a totally ordered address network, which carries its own requests and those of other nodes. Data replies come in on a separate, unordered data network. The controller holds the stable states NP, I, S, O and M, plus transient states. A transient state records two things independently: whether the node's own request has appeared in the global order, and whether the data has arrived.

The controller issues read-shared, read-exclusive, instruction-read and writeback requests. While it owns the line it supplies data to other requesters. Once its own exclusive request is ordered and the data has not yet arrived, any later requesters go into a one-hot forward set, and the completed block is sent to all of them when the data comes in. Stores carry a byte-enable mask, and the mask is merged over the fill data when the store completes.

Only one transaction can be outstanding on the line at a time. Every output is registered, so each pulse appears in the cycle after the clock edge that accepted its event. The address network has priority over the data network, and the data network has priority over the processor.

Top module: `snoop_line_coh`

## Requirements
- R1: After reset the line state is 0 (NP), the permission is 0 and the error flag is clear. A processor load is accepted at once.
- R2: State codes are NP=0, I=1, S=2, O=3, M=4, LD_AD=5, ST_AD=6, UP_AD=7, OU_A=8, LD_A=9, ST_A=10, UP_A=11, WB_M=12, WB_O=13, WB_I=14, LD_D=15, LD_DI=16, ST_D=17, ST_DO=18, ST_DI=19, ST_DOI=20, UP_D=21, UP_DO=22. Permission is 0 (none) in NP, I, WB_M and WB_I; 1 (read-only) in S and O; 2 (read-write) in M; and 3 (busy) in every other state.
- R3: Request codes are 0 read-shared, 1 read-exclusive, 2 instruction-read and 3 writeback. Processor op codes are 0 load, 1 fetch, 2 store and 3 evict. A load or fetch miss in NP or I issues code 0 or code 2 and enters LD_AD. Data arriving first leads to LD_A, and the node's own request arriving first leads to LD_D. Both paths end in S with one completion that carries the fill data.
- R4: If another node's read-exclusive is seen in LD_D, the state moves to LD_DI. When the data then arrives, the load completes once and the line ends in I.
- R5: A store from I enters ST_AD, and a store from S enters UP_AD. Both issue code 1. In UP_AD, another node's read-exclusive moves the line to ST_AD, and in UP_A it moves the line to ST_A. On completion the enabled store bytes overwrite the fill data, the store completion pulses and the line ends in M.
- R6: A store in O enters OU_A. When the node's own read-exclusive is seen there, the store completes into M with no data transfer.
- R7: An owner responds to another node's request by sending its line to that node. The response destination is a one-hot mask of the requesting node. From M, a read-shared leads to O. From M or O, a read-exclusive leads to I. S with another node's read-exclusive moves to I and sends no response.
- R8: Evicting M or O issues code 3 carrying the line data and enters WB_M or WB_O. In these states other nodes' requests are answered from the buffered copy, and a read-exclusive moves the line to WB_I. The node's own writeback returns the line to I.
- R9: In ST_D or UP_D, later requesters are added to the forward set (ST_DO, ST_DI, ST_DOI, UP_DO). When the data arrives the store completes and the merged block goes to every recorded node. The line ends in O if only shared reads were recorded, and in I if any read-exclusive was recorded.
- R10: The processor ready signal is low for demand operations in any transient state. It is also low whenever an address-network or data-network message is present.
- R11: A prefetch never produces a completion pulse. A prefetch to a line that already has enough permission is accepted and dropped, with no request issued.
- R12: Writeback requests from other nodes are ignored in every state. They cause no change of state and no output.
- R13: An event that has no defined transition in the current state sets a sticky error flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor operation present |
| cpuOp | input | 2 | 0 load, 1 fetch, 2 store, 3 evict |
| cpuPrefetch | input | 1 | Operation is a prefetch hint |
| cpuData | input | DW | Store data |
| cpuByteEn | input | DW/8 | Store byte enables |
| cpuReady | output | 1 | Operation accepted this cycle |
| snpValid | input | 1 | Ordered address-network message present |
| snpType | input | 2 | Request code of the message |
| snpSrc | input | IDW | Requesting node |
| datValid | input | 1 | Data-network message present |
| datData | input | DW | Data payload |
| datReady | output | 1 | Data message accepted this cycle |
| doneValid | output | 1 | Processor operation completed |
| doneStore | output | 1 | The completion is a store |
| doneData | output | DW | Line value after completion |
| reqValid | output | 1 | Request issued to the address network |
| reqType | output | 2 | Request code |
| reqData | output | DW | Line data carried by a writeback |
| rspValid | output | 1 | Data response issued |
| rspDest | output | NODES | One-hot or multi-hot destination mask |
| rspData | output | DW | Response data |
| lineState | output | 5 | Current state code |
| linePerm | output | 2 | Access permission code |
| protoErr | output | 1 | Sticky protocol error |

## Verification
Load misses are driven with the data arriving first and, separately, with the node's own request ordered first. This separates the two halves of the split transient states. Store misses are given intervening requests from other nodes: a shared read followed by an exclusive read, which shows that the forward set accumulates and that the final state depends on the mix of requests. Another pattern is an exclusive read that arrives before the node's own upgrade, which shows the fall back to a full miss and the byte merge over the fill data. Owner responses, writeback service from the buffer, prefetches that hit or miss, and contention between the networks and the processor each get their own sequence. Each sequence ends by checking the state code, the permission, and whether each output pulse is present or absent.

// File: rtl/snoop_line_pkg.sv
package snoop_line_pkg;

  typedef enum logic [4:0] {
    L_NP     = 5'd0,
    L_I      = 5'd1,
    L_S      = 5'd2,
    L_O      = 5'd3,
    L_M      = 5'd4,
    L_LD_AD  = 5'd5,
    L_ST_AD  = 5'd6,
    L_UP_AD  = 5'd7,
    L_OU_A   = 5'd8,
    L_LD_A   = 5'd9,
    L_ST_A   = 5'd10,
    L_UP_A   = 5'd11,
    L_WB_M   = 5'd12,
    L_WB_O   = 5'd13,
    L_WB_I   = 5'd14,
    L_LD_D   = 5'd15,
    L_LD_DI  = 5'd16,
    L_ST_D   = 5'd17,
    L_ST_DO  = 5'd18,
    L_ST_DI  = 5'd19,
    L_ST_DOI = 5'd20,
    L_UP_D   = 5'd21,
    L_UP_DO  = 5'd22
  } lineSt_e;

  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_FETCH = 2'd1, OP_STORE = 2'd2, OP_EVICT = 2'd3} cpuOp_e;
  typedef enum logic [1:0] {RQ_RDS = 2'd0, RQ_RDX = 2'd1, RQ_RDI = 2'd2, RQ_WB = 2'd3} busReq_e;
  typedef enum logic [1:0] {PERM_NONE = 2'd0, PERM_RO = 2'd1, PERM_RW = 2'd2, PERM_BUSY = 2'd3} perm_e;
  typedef enum logic [1:0] {SRC_LINE = 2'd0, SRC_BUF = 2'd1, SRC_NET = 2'd2} fillSrc_e;

  typedef struct packed {
    logic     capPend;
    logic     pendStore;
    logic     pfSet;
    logic     fwdClear;
    logic     fwdAdd;
    logic     fwdSend;
    logic     bufFromNet;
    logic     bufFromLine;
    logic     lineWr;
    fillSrc_e lineSrc;
    logic     useCpu;
    logic     doneFire;
    logic     doneMiss;
    logic     doneStore;
    logic     reqFire;
    busReq_e  reqType;
    logic     rspFire;
    logic     rspFromBuf;
  } dpCtl_t;

endpackage

// File: rtl/snoop_line_ctl.sv
module snoop_line_ctl
  import snoop_line_pkg::*;
#(
  parameter int IDW   = 2,
  parameter int MY_ID = 0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cpuValid,
  input  logic [1:0]     cpuOp,
  input  logic           cpuPrefetch,
  input  logic           snpValid,
  input  logic [1:0]     snpType,
  input  logic [IDW-1:0] snpSrc,
  input  logic           datValid,
  output logic           cpuReady,
  output logic           datReady,
  output dpCtl_t         ctl,
  output lineSt_e        state,
  output logic [1:0]     perm,
  output logic           protoErr
);

  lineSt_e nxt;
  logic    errNow;
  logic    cpuOk;
  logic    isStable;
  logic    isLd;
  logic    isSt;
  logic    snpOwn;
  logic    snpShared;
  logic    snpExcl;
  busReq_e sType;
  cpuOp_e  op;

  assign op        = cpuOp_e'(cpuOp);
  assign sType     = busReq_e'(snpType);
  assign snpOwn    = (snpSrc == IDW'(MY_ID));
  assign snpShared = (sType == RQ_RDS) || (sType == RQ_RDI);
  assign snpExcl   = (sType == RQ_RDX);
  assign isLd      = (op == OP_LOAD) || (op == OP_FETCH);
  assign isSt      = (op == OP_STORE);
  assign isStable  = state inside {L_NP, L_I, L_S, L_O, L_M};

  always_comb begin
    if (isStable) begin
      cpuOk = 1'b1;
    end else if (cpuPrefetch && isLd) begin
      cpuOk = !(state inside {L_LD_DI, L_ST_DI, L_ST_DOI, L_WB_M, L_WB_O, L_WB_I});
    end else if (cpuPrefetch && isSt) begin
      cpuOk = state inside {L_ST_AD, L_UP_AD, L_OU_A, L_ST_A, L_UP_A, L_ST_D, L_UP_D};
    end else begin
      cpuOk = 1'b0;
    end
  end

  assign cpuReady = cpuOk && !snpValid && !datValid;
  assign datReady = !snpValid;

  always_comb begin
    case (state)
      L_NP, L_I, L_WB_M, L_WB_I: perm = PERM_NONE;
      L_S, L_O:                  perm = PERM_RO;
      L_M:                       perm = PERM_RW;
      default:                   perm = PERM_BUSY;
    endcase
  end

  always_comb begin
    nxt    = state;
    ctl    = '0;
    errNow = 1'b0;
    if (snpValid) begin
      if (sType == RQ_WB && !snpOwn) begin
        nxt = state;
      end else if (snpOwn) begin
        if (snpShared) begin
          case (state)
            L_LD_AD: nxt = L_LD_D;
            L_LD_A: begin
              nxt = L_S; ctl.lineWr = 1'b1; ctl.lineSrc = SRC_BUF;
              ctl.doneFire = 1'b1; ctl.doneMiss = 1'b1;
            end
            default: errNow = 1'b1;
          endcase
        end else if (snpExcl) begin
          case (state)
            L_ST_AD: nxt = L_ST_D;
            L_UP_AD: nxt = L_UP_D;
            L_OU_A: begin
              nxt = L_M; ctl.lineWr = 1'b1; ctl.lineSrc = SRC_LINE;
              ctl.doneFire = 1'b1; ctl.doneMiss = 1'b1; ctl.doneStore = 1'b1;
            end
            L_ST_A, L_UP_A: begin
              nxt = L_M; ctl.lineWr = 1'b1; ctl.lineSrc = SRC_BUF;
              ctl.doneFire = 1'b1; ctl.doneMiss = 1'b1; ctl.doneStore = 1'b1;
            end
            default: errNow = 1'b1;
          endcase
        end else begin
          if (state inside {L_WB_M, L_WB_O, L_WB_I}) nxt = L_I;
          else errNow = 1'b1;
        end
      end else begin
        case (state)
          L_S: if (snpExcl) nxt = L_I;
          L_O: begin
            ctl.rspFire = 1'b1;
            if (snpExcl) nxt = L_I;
          end
          L_M: begin
            ctl.rspFire = 1'b1;
            nxt = snpExcl ? L_I : L_O;
          end
          L_UP_AD: if (snpExcl) nxt = L_ST_AD;
          L_UP_A:  if (snpExcl) nxt = L_ST_A;
          L_OU_A: begin
            ctl.rspFire = 1'b1;
            if (snpExcl) nxt = L_ST_AD;
          end
          L_WB_M, L_WB_O: begin
            ctl.rspFire = 1'b1; ctl.rspFromBuf = 1'b1;
            if (snpExcl) nxt = L_WB_I;
          end
          L_LD_D: if (snpExcl) nxt = L_LD_DI;
          L_ST_D: begin
            ctl.fwdAdd = 1'b1;
            nxt = snpExcl ? L_ST_DI : L_ST_DO;
          end
          L_ST_DO: begin
            ctl.fwdAdd = 1'b1;
            if (snpExcl) nxt = L_ST_DOI;
          end
          L_UP_D: begin
            ctl.fwdAdd = 1'b1;
            nxt = snpExcl ? L_ST_DI : L_UP_DO;
          end
          L_UP_DO: begin
            ctl.fwdAdd = 1'b1;
            if (snpExcl) nxt = L_ST_DOI;
          end
          default: nxt = state;
        endcase
      end
    end else if (datValid) begin
      case (state)
        L_LD_AD: begin nxt = L_LD_A; ctl.bufFromNet = 1'b1; end
        L_ST_AD, L_OU_A: begin nxt = L_ST_A; ctl.bufFromNet = 1'b1; end
        L_UP_AD: begin nxt = L_UP_A; ctl.bufFromNet = 1'b1; end
        L_LD_D, L_LD_DI: begin
          nxt = (state == L_LD_D) ? L_S : L_I;
          ctl.lineWr = 1'b1; ctl.lineSrc = SRC_NET;
          ctl.doneFire = 1'b1; ctl.doneMiss = 1'b1;
        end
        L_ST_D, L_UP_D, L_ST_DO, L_UP_DO, L_ST_DI, L_ST_DOI: begin
          ctl.lineWr = 1'b1; ctl.lineSrc = SRC_NET;
          ctl.doneFire = 1'b1; ctl.doneMiss = 1'b1; ctl.doneStore = 1'b1;
          if (state inside {L_ST_D, L_UP_D}) begin
            nxt = L_M;
          end else begin
            ctl.fwdSend = 1'b1;
            nxt = (state inside {L_ST_DO, L_UP_DO}) ? L_O : L_I;
          end
        end
        default: errNow = 1'b1;
      endcase
    end else if (cpuValid && cpuOk && isStable) begin
      case (state)
        L_NP, L_I: begin
          if (op == OP_EVICT) begin
            if (state == L_I) nxt = L_NP;
            else errNow = 1'b1;
          end else begin
            ctl.reqFire = 1'b1; ctl.capPend = 1'b1; ctl.fwdClear = 1'b1;
            ctl.pfSet = cpuPrefetch;
            if (isSt) begin
              ctl.reqType = RQ_RDX; ctl.pendStore = !cpuPrefetch; nxt = L_ST_AD;
            end else begin
              ctl.reqType = (op == OP_FETCH) ? RQ_RDI : RQ_RDS; nxt = L_LD_AD;
            end
          end
        end
        default: begin
          if (op == OP_EVICT) begin
            if (state == L_S) begin
              nxt = L_I;
            end else begin
              ctl.reqFire = 1'b1; ctl.reqType = RQ_WB; ctl.bufFromLine = 1'b1;
              nxt = (state == L_M) ? L_WB_M : L_WB_O;
            end
          end else if (isLd) begin
            ctl.doneFire = !cpuPrefetch;
          end else if (state == L_M) begin
            if (!cpuPrefetch) begin
              ctl.lineWr = 1'b1; ctl.lineSrc = SRC_LINE; ctl.useCpu = 1'b1;
              ctl.doneFire = 1'b1; ctl.doneStore = 1'b1;
            end
          end else begin
            ctl.reqFire = 1'b1; ctl.reqType = RQ_RDX; ctl.capPend = 1'b1;
            ctl.fwdClear = 1'b1; ctl.pfSet = cpuPrefetch; ctl.pendStore = !cpuPrefetch;
            if (state == L_O) nxt = L_OU_A;
            else nxt = cpuPrefetch ? L_ST_AD : L_UP_AD;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= L_NP;
      protoErr <= 1'b0;
    end else begin
      state    <= nxt;
      protoErr <= protoErr | errNow;
    end
  end

  // R13: the error flag never clears on its own
  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R2: the state register only holds defined codes
  a_r2_state_range: assert property (@(posedge clk) disable iff (!rstN)
    state <= L_UP_DO);

  // R3: data-first load miss completes to S on its own ordered request
  a_r3_ld_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == L_LD_A && snpValid && snpOwn && sType == RQ_RDS) |=> (state == L_S));

  // R8: own writeback ordering always returns the line to I
  a_r8_wb_done: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {L_WB_M, L_WB_O, L_WB_I} && snpValid && snpOwn && sType == RQ_WB)
      |=> (state == L_I));

endmodule

// File: rtl/snoop_line_dp.sv
module snoop_line_dp
  import snoop_line_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NODES = 4,
  parameter int IDW   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [DW-1:0]    cpuData,
  input  logic [DW/8-1:0]  cpuByteEn,
  input  logic [IDW-1:0]   snpSrc,
  input  logic [DW-1:0]    datData,
  output logic             doneValid,
  output logic             doneStore,
  output logic [DW-1:0]    doneData,
  output logic             reqValid,
  output logic [1:0]       reqType,
  output logic [DW-1:0]    reqData,
  output logic             rspValid,
  output logic [NODES-1:0] rspDest,
  output logic [DW-1:0]    rspData
);

  localparam int NB = DW / 8;

  logic [DW-1:0]    lineQ;
  logic [DW-1:0]    bufQ;
  logic [DW-1:0]    pendData;
  logic [NB-1:0]    pendMask;
  logic             pfQ;
  logic [NODES-1:0] fwdQ;
  logic [NODES-1:0] srcHot;
  logic [DW-1:0]    fillVal;
  logic [DW-1:0]    mergeData;
  logic [NB-1:0]    mergeMask;
  logic [DW-1:0]    lineNew;
  logic [DW-1:0]    lineAfter;

  assign srcHot = NODES'(1) << snpSrc;

  always_comb begin
    case (ctl.lineSrc)
      SRC_BUF: fillVal = bufQ;
      SRC_NET: fillVal = datData;
      default: fillVal = lineQ;
    endcase
  end

  assign mergeData = ctl.useCpu ? cpuData : pendData;
  assign mergeMask = ctl.useCpu ? cpuByteEn : pendMask;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign lineNew[8*b +: 8] = mergeMask[b] ? mergeData[8*b +: 8] : fillVal[8*b +: 8];
  end

  assign lineAfter = ctl.lineWr ? lineNew : lineQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ    <= '0;
      bufQ     <= '0;
      pendData <= '0;
      pendMask <= '0;
      pfQ      <= 1'b0;
      fwdQ     <= '0;
    end else begin
      if (ctl.lineWr) lineQ <= lineNew;
      if (ctl.bufFromNet) bufQ <= datData;
      else if (ctl.bufFromLine) bufQ <= lineQ;
      if (ctl.capPend) begin
        pendData <= cpuData;
        pendMask <= ctl.pendStore ? cpuByteEn : '0;
        pfQ      <= ctl.pfSet;
      end
      if (ctl.fwdClear) fwdQ <= '0;
      else if (ctl.fwdAdd) fwdQ <= fwdQ | srcHot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneStore <= 1'b0;
      doneData  <= '0;
      reqValid  <= 1'b0;
      reqType   <= '0;
      reqData   <= '0;
      rspValid  <= 1'b0;
      rspDest   <= '0;
      rspData   <= '0;
    end else begin
      doneValid <= ctl.doneFire && !(ctl.doneMiss && pfQ);
      doneStore <= ctl.doneStore;
      doneData  <= lineAfter;
      reqValid  <= ctl.reqFire;
      reqType   <= ctl.reqType;
      reqData   <= lineQ;
      rspValid  <= ctl.rspFire || ctl.fwdSend;
      rspDest   <= ctl.fwdSend ? fwdQ : srcHot;
      rspData   <= ctl.fwdSend ? lineNew : (ctl.rspFromBuf ? bufQ : lineQ);
    end
  end

  // R9: a forward is only sent after at least one requester was recorded
  a_r9_fwd_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fwdSend |-> (fwdQ != '0));

  // R7: every data response names at least one destination
  a_r7_rsp_dest: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspDest != '0));

endmodule

// File: rtl/snoop_line_coh.sv
module snoop_line_coh
  import snoop_line_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NODES = 4,
  parameter int MY_ID = 0,
  localparam int IDW  = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuValid,
  input  logic [1:0]       cpuOp,
  input  logic             cpuPrefetch,
  input  logic [DW-1:0]    cpuData,
  input  logic [DW/8-1:0]  cpuByteEn,
  output logic             cpuReady,
  input  logic             snpValid,
  input  logic [1:0]       snpType,
  input  logic [IDW-1:0]   snpSrc,
  input  logic             datValid,
  input  logic [DW-1:0]    datData,
  output logic             datReady,
  output logic             doneValid,
  output logic             doneStore,
  output logic [DW-1:0]    doneData,
  output logic             reqValid,
  output logic [1:0]       reqType,
  output logic [DW-1:0]    reqData,
  output logic             rspValid,
  output logic [NODES-1:0] rspDest,
  output logic [DW-1:0]    rspData,
  output logic [4:0]       lineState,
  output logic [1:0]       linePerm,
  output logic             protoErr
);

  dpCtl_t  ctl;
  lineSt_e stateQ;

  snoop_line_ctl #(.IDW(IDW), .MY_ID(MY_ID)) u_ctl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuOp(cpuOp), .cpuPrefetch(cpuPrefetch),
    .snpValid(snpValid), .snpType(snpType), .snpSrc(snpSrc),
    .datValid(datValid),
    .cpuReady(cpuReady), .datReady(datReady),
    .ctl(ctl), .state(stateQ), .perm(linePerm), .protoErr(protoErr)
  );

  snoop_line_dp #(.DW(DW), .NODES(NODES), .IDW(IDW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cpuData(cpuData), .cpuByteEn(cpuByteEn), .snpSrc(snpSrc), .datData(datData),
    .doneValid(doneValid), .doneStore(doneStore), .doneData(doneData),
    .reqValid(reqValid), .reqType(reqType), .reqData(reqData),
    .rspValid(rspValid), .rspDest(rspDest), .rspData(rspData)
  );

  assign lineState = stateQ;

  // R10: no processor operation is taken while a network message is present
  a_r10_net_first: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid || datValid) |-> !cpuReady);

endmodule

// File: tb/snoop_line_coh_bench.sv
`timescale 1ns/1ps
module snoop_line_coh_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0;
  logic [1:0]  cpuOp = '0;
  logic        cpuPrefetch = 1'b0;
  logic [31:0] cpuData = '0;
  logic [3:0]  cpuByteEn = '0;
  logic        cpuReady;
  logic        snpValid = 1'b0;
  logic [1:0]  snpType = '0;
  logic [1:0]  snpSrc = '0;
  logic        datValid = 1'b0;
  logic [31:0] datData = '0;
  logic        datReady;
  logic        doneValid, doneStore;
  logic [31:0] doneData;
  logic        reqValid;
  logic [1:0]  reqType;
  logic [31:0] reqData;
  logic        rspValid;
  logic [3:0]  rspDest;
  logic [31:0] rspData;
  logic [4:0]  lineState;
  logic [1:0]  linePerm;
  logic        protoErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  snoop_line_coh u_snoop_line_coh (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuOp(cpuOp), .cpuPrefetch(cpuPrefetch),
    .cpuData(cpuData), .cpuByteEn(cpuByteEn), .cpuReady(cpuReady),
    .snpValid(snpValid), .snpType(snpType), .snpSrc(snpSrc),
    .datValid(datValid), .datData(datData), .datReady(datReady),
    .doneValid(doneValid), .doneStore(doneStore), .doneData(doneData),
    .reqValid(reqValid), .reqType(reqType), .reqData(reqData),
    .rspValid(rspValid), .rspDest(rspDest), .rspData(rspData),
    .lineState(lineState), .linePerm(linePerm), .protoErr(protoErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cpuValid = 1'b0; cpuPrefetch = 1'b0;
    snpValid = 1'b0; datValid = 1'b0;
  endtask

  task automatic cpu(input logic [1:0] op, input logic pf, input logic [31:0] d, input logic [3:0] be);
    cpuValid = 1'b1; cpuOp = op; cpuPrefetch = pf; cpuData = d; cpuByteEn = be;
    tick();
  endtask

  task automatic snoop(input logic [1:0] t, input logic [1:0] src);
    snpValid = 1'b1; snpType = t; snpSrc = src;
    tick();
  endtask

  task automatic data(input logic [31:0] d);
    datValid = 1'b1; datData = d;
    tick();
  endtask

  task automatic testReset();
    chk("R1 state", 32'(lineState), 0);
    chk("R1 perm", 32'(linePerm), 0);
    chk("R1 err", 32'(protoErr), 0);
    cpuValid = 1'b1; cpuOp = 2'd0; #1;
    chk("R1 ready", 32'(cpuReady), 1);
    cpuValid = 1'b0;
  endtask

  task automatic testLoadDataFirst();
    cpu(2'd0, 0, 0, 0);
    chk("R3 req", 32'(reqValid), 1);
    chk("R3 req type", 32'(reqType), 0);
    chk("R3 state LD_AD", 32'(lineState), 5);
    chk("R2 busy perm", 32'(linePerm), 3);
    data(32'h11223344);
    chk("R3 state LD_A", 32'(lineState), 9);
    chk("R3 no early done", 32'(doneValid), 0);
    cpuValid = 1'b1; cpuOp = 2'd2; #1;
    chk("R10 stall store", 32'(cpuReady), 0);
    cpuValid = 1'b0;
    snoop(2'd0, 2'd0);
    chk("R3 state S", 32'(lineState), 2);
    chk("R3 done", 32'(doneValid), 1);
    chk("R3 done data", doneData, 32'h11223344);
    chk("R3 done kind", 32'(doneStore), 0);
    chk("R2 S perm", 32'(linePerm), 1);
    cpu(2'd0, 0, 0, 0);
    chk("R3 hit done", 32'(doneValid), 1);
    chk("R3 hit data", doneData, 32'h11223344);
  endtask

  task automatic testLoadOrderFirst();
    cpu(2'd3, 0, 0, 0);
    chk("R2 evict S to I", 32'(lineState), 1);
    cpu(2'd1, 0, 0, 0);
    chk("R3 fetch req type", 32'(reqType), 2);
    snoop(2'd2, 2'd0);
    chk("R3 state LD_D", 32'(lineState), 15);
    snoop(2'd1, 2'd2);
    chk("R4 state LD_DI", 32'(lineState), 16);
    chk("R4 no done yet", 32'(doneValid), 0);
    data(32'h55667788);
    chk("R4 done", 32'(doneValid), 1);
    chk("R4 data", doneData, 32'h55667788);
    chk("R4 end I", 32'(lineState), 1);
    tick();
    chk("R4 single done", 32'(doneValid), 0);
  endtask

  task automatic testForward();
    cpu(2'd2, 0, 32'hAAAABBBB, 4'b0011);
    chk("R5 req type", 32'(reqType), 1);
    chk("R5 state ST_AD", 32'(lineState), 6);
    snoop(2'd1, 2'd0);
    chk("R9 state ST_D", 32'(lineState), 17);
    snoop(2'd0, 2'd2);
    chk("R9 state ST_DO", 32'(lineState), 18);
    chk("R9 no rsp yet", 32'(rspValid), 0);
    snoop(2'd1, 2'd3);
    chk("R9 state ST_DOI", 32'(lineState), 20);
    data(32'h12345678);
    chk("R9 done store", 32'(doneStore), 1);
    chk("R9 merged", doneData, 32'h1234BBBB);
    chk("R9 rsp", 32'(rspValid), 1);
    chk("R9 rsp dest", 32'(rspDest), 4'b1100);
    chk("R9 rsp data", rspData, 32'h1234BBBB);
    chk("R9 end I", 32'(lineState), 1);
  endtask

  task automatic testUpgradeRace();
    cpu(2'd0, 0, 0, 0);
    snoop(2'd0, 2'd0);
    data(32'hCAFEF00D);
    chk("R3 order-first S", 32'(lineState), 2);
    cpu(2'd2, 0, 32'h99000000, 4'b1000);
    chk("R5 state UP_AD", 32'(lineState), 7);
    snoop(2'd1, 2'd1);
    chk("R5 drop to ST_AD", 32'(lineState), 6);
    data(32'hDEADBEEF);
    chk("R5 state ST_A", 32'(lineState), 10);
    snoop(2'd1, 2'd0);
    chk("R5 state M", 32'(lineState), 4);
    chk("R5 done", 32'(doneValid), 1);
    chk("R5 merge", doneData, 32'h99ADBEEF);
    chk("R2 M perm", 32'(linePerm), 2);
  endtask

  task automatic testOwner();
    snoop(2'd0, 2'd1);
    chk("R7 rsp", 32'(rspValid), 1);
    chk("R7 dest", 32'(rspDest), 4'b0010);
    chk("R7 data", rspData, 32'h99ADBEEF);
    chk("R7 M to O", 32'(lineState), 3);
    cpu(2'd2, 0, 32'h000000EE, 4'b0001);
    chk("R6 state OU_A", 32'(lineState), 8);
    snoop(2'd1, 2'd0);
    chk("R6 to M", 32'(lineState), 4);
    chk("R6 done", 32'(doneValid), 1);
    chk("R6 data", doneData, 32'h99ADBEEE);
    snoop(2'd3, 2'd2);
    chk("R12 state kept", 32'(lineState), 4);
    chk("R12 no rsp", 32'(rspValid), 0);
    chk("R12 no req", 32'(reqValid), 0);
    snoop(2'd1, 2'd3);
    chk("R7 excl rsp dest", 32'(rspDest), 4'b1000);
    chk("R7 excl data", rspData, 32'h99ADBEEE);
    chk("R7 M to I", 32'(lineState), 1);
  endtask

  task automatic testWriteback();
    cpu(2'd2, 0, 32'h0BADCAFE, 4'b1111);
    snoop(2'd1, 2'd0);
    data(32'h0);
    chk("R5 full store", doneData, 32'h0BADCAFE);
    chk("R9 no forward", 32'(rspValid), 0);
    cpu(2'd3, 0, 0, 0);
    chk("R8 req", 32'(reqValid), 1);
    chk("R8 req type", 32'(reqType), 3);
    chk("R8 req data", reqData, 32'h0BADCAFE);
    chk("R8 state WB_M", 32'(lineState), 12);
    chk("R2 WB_M perm", 32'(linePerm), 0);
    snoop(2'd0, 2'd1);
    chk("R8 buf rsp", rspData, 32'h0BADCAFE);
    chk("R8 buf dest", 32'(rspDest), 4'b0010);
    snoop(2'd1, 2'd2);
    chk("R8 state WB_I", 32'(lineState), 14);
    chk("R8 excl dest", 32'(rspDest), 4'b0100);
    snoop(2'd3, 2'd0);
    chk("R8 back to I", 32'(lineState), 1);
  endtask

  task automatic testPrefetch();
    cpu(2'd0, 1, 0, 0);
    chk("R11 pf req", 32'(reqValid), 1);
    snoop(2'd0, 2'd0);
    data(32'h0F0F0F0F);
    chk("R11 pf fill S", 32'(lineState), 2);
    chk("R11 pf no done", 32'(doneValid), 0);
    cpuValid = 1'b1; cpuOp = 2'd0; cpuPrefetch = 1'b1; #1;
    chk("R11 pf hit ready", 32'(cpuReady), 1);
    tick();
    chk("R11 pf hit no req", 32'(reqValid), 0);
    chk("R11 pf hit no done", 32'(doneValid), 0);
    chk("R11 pf hit state", 32'(lineState), 2);
    cpu(2'd0, 0, 0, 0);
    chk("R11 demand after pf", 32'(doneValid), 1);
    chk("R11 demand data", doneData, 32'h0F0F0F0F);
  endtask

  task automatic testContention();
    cpuValid = 1'b1; cpuOp = 2'd0; snpValid = 1'b1; snpType = 2'd0; snpSrc = 2'd3; #1;
    chk("R10 ready low on snoop", 32'(cpuReady), 0);
    tick();
    chk("R10 no done", 32'(doneValid), 0);
    chk("R7 S no rsp", 32'(rspValid), 0);
    chk("R10 state S", 32'(lineState), 2);
    snoop(2'd1, 2'd1);
    chk("R7 S to I", 32'(lineState), 1);
  endtask

  task automatic testError();
    cpu(2'd0, 0, 0, 0);
    snoop(2'd0, 2'd0);
    data(32'h1);
    chk("R13 clear before", 32'(protoErr), 0);
    data(32'h2);
    chk("R13 err set", 32'(protoErr), 1);
    chk("R13 state kept", 32'(lineState), 2);
    tick();
    chk("R13 sticky", 32'(protoErr), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testLoadDataFirst();
    testLoadOrderFirst();
    testForward();
    testUpgradeRace();
    testOwner();
    testWriteback();
    testPrefetch();
    testContention();
    testError();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule